// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This engine moves one device-side byte buffer at a time between the device and system memory. It does this by walking a table of region descriptors that lives in memory. Each descriptor is an 8-byte word pair that names a memory region and its length, and may mark the end of the table. The engine reads descriptors through a fetch port with a valid/ready request and a one-beat response. It then issues data requests of at most 16 bytes on a separate memory port. Each request carries the memory address, the byte count, the direction and the offset inside the device buffer. The data path itself is not part of this block.

A controller first loads the table base with a rewind pulse and clears any region in progress with a fresh-command pulse. It then hands over buffers one by one, each with its length and direction. For each buffer the engine reports one completion: either the buffer was fully moved, or the table ran out first. A region that is only partly used when a buffer ends is kept, and the next buffer picks up from the same place. The walk also ends when the descriptor pointer has travelled one page past the table base, even if no descriptor carries the end flag.

Top module: `sg_table_walker`

## Requirements
- R1: A fetched 64-bit response word is decoded as follows. Bits 31:0 give the region address. Bits 47:32 give the count, with bit 32 forced to zero, so the region length is `{bits[47:33],1'b0}`.
- R2: A decoded count of zero stands for a region of 65536 bytes.
- R3: Bit 63 of the response marks the last descriptor. Once that region is used up, no further descriptor is fetched.
- R4: Descriptor fetches are issued at the table base plus 8·k for k = 0, 1, 2, …, and the pointer advances by 8 per fetch. A fetch happens only when the current region is empty and the buffer still has bytes to move. A stalled request holds its address.
- R5: No fetch is issued once the pointer is 4096 or more bytes past the table base. In that case the walk ends as if the last flag had been seen.
- R6: Each data request moves min(16, bytes left in buffer, bytes left in region) bytes, at the current region address. After the handshake the region address advances by that count and the region length drops by the same amount. A stalled request holds its address and length.
- R7: A region that still has bytes when a buffer finishes is not dropped. The next buffer continues from it without a new fetch.
- R8: Each buffer ends with a one-cycle `done_o`. `status_o` = 1 means the buffer was fully moved; 2 means the table ended first. A zero-length buffer completes with status 1, with no fetch and no data request.
- R9: A rewind pulse (`rewind_i`) reloads both the descriptor pointer and the fail-safe base from `table_base_i`. A fresh-command pulse (`fresh_i`) clears the region address, the region length and the last flag, but leaves the pointer where it is.
- R10: `mem_we_o` equals the direction latched with the buffer: 1 = device to memory (memory write), 0 = memory to device.
- R11: `buf_off_o` gives the byte offset in the device buffer of the current request. It starts at 0 for each buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| table_base_i | input | 32 | Table base address, taken on rewind |
| rewind_i | input | 1 | Reload descriptor pointer from base (accepted when idle) |
| fresh_i | input | 1 | Clear current region state (accepted when idle) |
| go_i | input | 1 | Start moving one device buffer (accepted when idle) |
| dir_i | input | 1 | 1 = device to memory, 0 = memory to device |
| buf_len_i | input | 17 | Device buffer length in bytes |
| busy_o | output | 1 | Engine is working on a buffer |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Completion code: 1 buffer done, 2 table exhausted |
| dreq_valid_o | output | 1 | Descriptor fetch request valid |
| dreq_ready_i | input | 1 | Descriptor fetch request accepted |
| dreq_addr_o | output | 32 | Descriptor fetch address |
| drsp_valid_i | input | 1 | Descriptor response valid |
| drsp_data_i | input | 64 | Descriptor response, address in low word |
| mem_valid_o | output | 1 | Data request valid |
| mem_ready_i | input | 1 | Data request accepted |
| mem_we_o | output | 1 | Data request is a memory write |
| mem_addr_o | output | 32 | Data request memory address |
| mem_len_o | output | 5 | Data request byte count (1 to 16) |
| buf_off_o | output | 17 | Device buffer offset of the data request |

## Verification
The bench targets several corner cases, each named with the failure it would expose:

- Count word with bit 0 set: a design that forgets the mask moves one byte too many.
- Count of zero, and count of one: a design that misses the 64 KiB case emits a zero-length request or ends at once.
- Buffer ends inside a region: a design that drops the region fetches the next descriptor and moves the wrong addresses.
- Table of 512 unflagged descriptors: a design without the page fail-safe fetches a 513th descriptor.
- Fresh command without a rewind: a design that also rewinds re-fetches descriptor 0 instead of 1.

Ready signals stall in fixed patterns, so any request that changes while stalled is counted as a second, mismatched transfer.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int DESC_BYTES = 8;
  localparam int CNT_BITS   = 16;
  localparam int DESC_W     = 64;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FREQ, S_FWAIT, S_XFER
  } sgw_state_e;

  typedef enum logic [1:0] {
    CPL_NONE = 2'd0,
    CPL_OK   = 2'd1,
    CPL_EXH  = 2'd2
  } sgw_cpl_e;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = CNT_BITS + 1
) (
  input  logic [DESC_W-1:0] desc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              last_o
);
  logic [CNT_BITS-1:0] cnt_m;

  // bit 0 of the count is never honoured
  assign cnt_m  = {desc_i[33 +: CNT_BITS-1], 1'b0};
  assign addr_o = desc_i[ADDR_W-1:0];
  assign len_o  = (cnt_m == '0) ? (LEN_W'(1) << CNT_BITS) : LEN_W'(cnt_m);
  assign last_o = desc_i[DESC_W-1];
endmodule

// File: rtl/sgw_region.sv
module sgw_region #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [LEN_W-1:0]  load_len_i,
  input  logic              load_last_i,
  input  logic              take_i,
  input  logic [LEN_W-1:0]  take_amt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= '0;
      last_q <= 1'b0;
    end else if (clear_i) begin
      addr_q <= '0;
      len_q  <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      addr_q <= load_addr_i;
      len_q  <= load_len_i;
      last_q <= load_last_i;
    end else if (take_i) begin
      addr_q <= addr_q + ADDR_W'(take_amt_i);
      len_q  <= len_q - take_amt_i;
    end
  end

  assign addr_o = addr_q;
  assign len_o  = len_q;
  assign last_o = last_q;

  // R6
  take_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (take_amt_i != '0) && (take_amt_i <= len_q));
  // R2
  load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> load_len_i != '0);
endmodule

// File: rtl/sgw_burst_sel.sv
module sgw_burst_sel #(
  parameter int BUF_W     = 17,
  parameter int LEN_W     = 17,
  parameter int BURST_MAX = 16,
  parameter int BURST_W   = 5
) (
  input  logic [BUF_W-1:0]   buf_left_i,
  input  logic [LEN_W-1:0]   reg_left_i,
  output logic [BURST_W-1:0] n_o
);
  localparam int MW = (BUF_W > LEN_W) ? BUF_W : LEN_W;

  logic [MW-1:0] b, r, cap, m1, m2;

  always_comb begin
    b   = MW'(buf_left_i);
    r   = MW'(reg_left_i);
    cap = MW'(BURST_MAX);
    m1  = (b < r) ? b : r;
    m2  = (m1 < cap) ? m1 : cap;
    n_o = BURST_W'(m2);
  end
endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUF_W      = 17,
  parameter int BURST_MAX  = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int LEN_W     = CNT_BITS + 1,
  localparam int BURST_W   = $clog2(BURST_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  table_base_i,
  input  logic               rewind_i,
  input  logic               fresh_i,
  input  logic               go_i,
  input  logic               dir_i,
  input  logic [BUF_W-1:0]   buf_len_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         status_o,
  output logic               dreq_valid_o,
  input  logic               dreq_ready_i,
  output logic [ADDR_W-1:0]  dreq_addr_o,
  input  logic               drsp_valid_i,
  input  logic [DESC_W-1:0]  drsp_data_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [BURST_W-1:0] mem_len_o,
  output logic [BUF_W-1:0]   buf_off_o
);
  sgw_state_e        state_q;
  sgw_cpl_e          status_q;
  logic [ADDR_W-1:0] base_q, ptr_q, walked;
  logic [BUF_W-1:0]  buf_left_q, buf_off_q;
  logic              dir_q, done_q;

  logic [ADDR_W-1:0] dec_addr, reg_addr;
  logic [LEN_W-1:0]  dec_len, reg_len;
  logic              dec_last, reg_last;
  logic [BURST_W-1:0] n_cur;
  logic              reg_clear, reg_load, reg_take, walk_end;

  sgw_desc_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .desc_i (drsp_data_i),
    .addr_o (dec_addr),
    .len_o  (dec_len),
    .last_o (dec_last)
  );

  assign reg_clear = (state_q == S_IDLE) && fresh_i;
  assign reg_load  = (state_q == S_FWAIT) && drsp_valid_i;
  assign reg_take  = (state_q == S_XFER) && mem_ready_i;

  sgw_region #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (reg_clear),
    .load_i      (reg_load),
    .load_addr_i (dec_addr),
    .load_len_i  (dec_len),
    .load_last_i (dec_last),
    .take_i      (reg_take),
    .take_amt_i  (LEN_W'(n_cur)),
    .addr_o      (reg_addr),
    .len_o       (reg_len),
    .last_o      (reg_last)
  );

  sgw_burst_sel #(
    .BUF_W(BUF_W), .LEN_W(LEN_W), .BURST_MAX(BURST_MAX), .BURST_W(BURST_W)
  ) u_sel (
    .buf_left_i (buf_left_q),
    .reg_left_i (reg_len),
    .n_o        (n_cur)
  );

  assign walked   = ptr_q - base_q;
  // page fail-safe or flagged end stops the walk
  assign walk_end = reg_last || (walked >= ADDR_W'(PAGE_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      status_q   <= CPL_NONE;
      base_q     <= '0;
      ptr_q      <= '0;
      buf_left_q <= '0;
      buf_off_q  <= '0;
      dir_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (rewind_i) begin
            base_q <= table_base_i;
            ptr_q  <= table_base_i;
          end
          if (go_i) begin
            buf_left_q <= buf_len_i;
            buf_off_q  <= '0;
            dir_q      <= dir_i;
            state_q    <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (buf_left_q == '0) begin
            done_q   <= 1'b1;
            status_q <= CPL_OK;
            state_q  <= S_IDLE;
          end else if (reg_len == '0) begin
            if (walk_end) begin
              done_q   <= 1'b1;
              status_q <= CPL_EXH;
              state_q  <= S_IDLE;
            end else begin
              state_q <= S_FREQ;
            end
          end else begin
            state_q <= S_XFER;
          end
        end
        S_FREQ: begin
          if (dreq_ready_i) begin
            ptr_q   <= ptr_q + ADDR_W'(DESC_BYTES);
            state_q <= S_FWAIT;
          end
        end
        S_FWAIT: begin
          if (drsp_valid_i) state_q <= S_CHECK;
        end
        S_XFER: begin
          if (mem_ready_i) begin
            buf_left_q <= buf_left_q - BUF_W'(n_cur);
            buf_off_q  <= buf_off_q + BUF_W'(n_cur);
            state_q    <= S_CHECK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign status_o     = status_q;
  assign dreq_valid_o = (state_q == S_FREQ);
  assign dreq_addr_o  = ptr_q;
  assign mem_valid_o  = (state_q == S_XFER);
  assign mem_we_o     = dir_q;
  assign mem_addr_o   = reg_addr;
  assign mem_len_o    = n_cur;
  assign buf_off_o    = buf_off_q;

  // R4
  dreq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_valid_o && !dreq_ready_i |=> dreq_valid_o && $stable(dreq_addr_o));
  // R5
  walk_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_valid_o |-> (dreq_addr_o - base_q) < ADDR_W'(PAGE_BYTES));
  // R6
  burst_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_len_o != '0) && (mem_len_o <= BURST_W'(BURST_MAX)));
  // R6
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_len_o));
  // R4
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dreq_valid_o && mem_valid_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o == CPL_OK) || (status_o == CPL_EXH));
endmodule

// File: tb/tb_sg_table_walker.sv
module tb_sg_table_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] table_base_i = '0;
  logic        rewind_i = 1'b0, fresh_i = 1'b0, go_i = 1'b0, dir_i = 1'b0;
  logic [16:0] buf_len_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  status_o;
  logic        dreq_valid_o, dreq_ready_i = 1'b0;
  logic [31:0] dreq_addr_o;
  logic        drsp_valid_i = 1'b0;
  logic [63:0] drsp_data_i = '0;
  logic        mem_valid_o, mem_ready_i = 1'b0, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [4:0]  mem_len_o;
  logic [16:0] buf_off_o;

  always #10 clk_i = ~clk_i;

  sg_table_walker dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .table_base_i(table_base_i),
    .rewind_i(rewind_i), .fresh_i(fresh_i), .go_i(go_i), .dir_i(dir_i),
    .buf_len_i(buf_len_i), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .dreq_valid_o(dreq_valid_o), .dreq_ready_i(dreq_ready_i), .dreq_addr_o(dreq_addr_o),
    .drsp_valid_i(drsp_valid_i), .drsp_data_i(drsp_data_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o), .buf_off_o(buf_off_o)
  );

  logic [63:0] tbl [0:599];
  int n_chk = 0, n_bad = 0;
  int cyc = 0, wd = 0, done_cnt = 0, fetch_cnt = 0, obs_bytes = 0;
  logic [31:0] m_base = '0, m_ptr = '0, m_raddr = '0, last_fetch = '0;
  int  m_rlen = 0, m_buf = 0, m_off = 0;
  bit  m_last = 0, m_dir = 0, rsp_pend = 0;
  logic [63:0] rsp_word = '0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and per-event checks
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (rsp_pend) begin
        drsp_valid_i = 1'b1;
        drsp_data_i  = rsp_word;
        rsp_pend     = 0;
      end else begin
        drsp_valid_i = 1'b0;
      end
      dreq_ready_i = (cyc % 2 == 0);
      mem_ready_i  = (cyc % 3 != 1);
      if (dreq_valid_o && dreq_ready_i) begin
        int idx;
        logic [15:0] msk;
        chk(m_buf > 0 && m_rlen == 0 && !m_last && (m_ptr - m_base) < 32'd4096,
            "R5 R3 fetch not due", 1, 0);
        chk(dreq_addr_o == m_ptr, "R4 fetch addr", dreq_addr_o, m_ptr);
        idx = int'((dreq_addr_o - m_base) >> 3);
        rsp_word = (idx >= 0 && idx < 600) ? tbl[idx] : 64'h0;
        rsp_pend = 1;
        last_fetch = dreq_addr_o;
        fetch_cnt++;
        m_ptr  = m_ptr + 32'd8;
        msk    = rsp_word[47:32] & 16'hFFFE;
        m_rlen = (msk == 16'h0) ? 65536 : int'(msk);
        m_raddr = rsp_word[31:0];
        m_last = rsp_word[63];
      end
      if (mem_valid_o && mem_ready_i) begin
        int en;
        en = (m_buf < m_rlen) ? m_buf : m_rlen;
        if (en > 16) en = 16;
        chk(m_buf > 0 && m_rlen > 0, "R6 burst not due", mem_len_o, 0);
        chk(mem_addr_o == m_raddr, "R1 R6 burst addr", mem_addr_o, m_raddr);
        chk(int'(mem_len_o) == en, "R6 burst len", mem_len_o, en);
        chk(mem_we_o == m_dir, "R10 direction", mem_we_o, m_dir);
        chk(int'(buf_off_o) == m_off, "R11 buffer offset", buf_off_o, m_off);
        m_raddr = m_raddr + 32'(mem_len_o);
        m_rlen  = m_rlen - int'(mem_len_o);
        m_buf   = m_buf - int'(mem_len_o);
        m_off   = m_off + int'(mem_len_o);
        obs_bytes = obs_bytes + int'(mem_len_o);
      end
      if (done_o) begin
        int ex;
        ex = (m_buf == 0) ? 1 :
             (m_rlen == 0 && (m_last || (m_ptr - m_base) >= 32'd4096)) ? 2 : 0;
        chk(int'(status_o) == ex, "R8 completion code", status_o, ex);
        done_cnt++;
      end
    end
  end

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic rewind(input logic [31:0] base);
    @(negedge clk_i);
    table_base_i = base; rewind_i = 1'b1;
    m_base = base; m_ptr = base;
    @(negedge clk_i);
    rewind_i = 1'b0;
  endtask

  task automatic fresh();
    @(negedge clk_i);
    fresh_i = 1'b1;
    m_rlen = 0; m_last = 0; m_raddr = '0;
    @(negedge clk_i);
    fresh_i = 1'b0;
  endtask

  task automatic run(input int len, input bit dir, input int exp_st, input string req);
    int d0;
    d0 = done_cnt;
    @(negedge clk_i);
    m_buf = len; m_off = 0; m_dir = dir; obs_bytes = 0;
    buf_len_i = 17'(len); dir_i = dir; go_i = 1'b1;
    @(negedge clk_i);
    go_i = 1'b0;
    while (done_cnt == d0) @(negedge clk_i);
    chk(int'(status_o) == exp_st, req, status_o, exp_st);
    chk(!busy_o, "R8 idle after done", busy_o, 0);
  endtask

  initial begin
    int f0;
    for (int i = 0; i < 600; i++) tbl[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && status_o == 2'd0, "R8 reset state", {busy_o, done_o, status_o}, 0);
    chk(!dreq_valid_o && !mem_valid_o, "R4 R6 reset idle ports", {dreq_valid_o, mem_valid_o}, 0);

    // single flagged region, device to memory
    tbl[0] = {32'h8000_0028, 32'h2000_0000};
    rewind(32'h1000_0000); fresh();
    run(40, 1'b1, 1, "R1 R3 single region done");
    chk(obs_bytes == 40, "R6 bytes moved", obs_bytes, 40);

    // count bit 0 ignored, memory to device
    tbl[0] = {32'h8000_0021, 32'h2000_0100};
    rewind(32'h1000_0000); fresh();
    run(40, 1'b0, 2, "R1 masked count exhausts");
    chk(obs_bytes == 32, "R1 masked count bytes", obs_bytes, 32);

    // region carried across buffers, then table end
    tbl[0] = {32'h0000_0040, 32'h2000_1000};
    tbl[1] = {32'h8000_0020, 32'h2000_2000};
    rewind(32'h1000_0000); fresh();
    run(24, 1'b1, 1, "R7 first part");
    f0 = fetch_cnt;
    run(24, 1'b1, 1, "R7 continued part");
    chk(fetch_cnt == f0, "R7 no refetch", fetch_cnt, f0);
    run(60, 1'b0, 2, "R3 last flag exhausts");
    chk(obs_bytes == 48, "R3 bytes before end", obs_bytes, 48);

    // fresh without rewind keeps the pointer
    tbl[0] = {32'h0000_0040, 32'h2000_3000};
    tbl[1] = {32'h8000_0010, 32'h2000_4000};
    rewind(32'h1000_0000); fresh();
    run(8, 1'b1, 1, "R9 partial region");
    fresh();
    run(16, 1'b1, 1, "R9 fresh then buffer");
    chk(last_fetch == 32'h1000_0008, "R9 pointer kept by fresh", last_fetch, 32'h1000_0008);

    // zero-length buffer
    f0 = fetch_cnt;
    fresh();
    run(0, 1'b0, 1, "R8 zero length");
    chk(fetch_cnt == f0, "R8 zero length no fetch", fetch_cnt, f0);

    // zero count means 64 KiB (bit 0 set too)
    tbl[0] = {32'h8000_0001, 32'h3000_0000};
    rewind(32'h1000_0000); fresh();
    run(65556, 1'b1, 2, "R2 big region exhausts");
    chk(obs_bytes == 65536, "R2 region of 65536", obs_bytes, 65536);

    // no end flag: page fail-safe after 512 descriptors
    for (int i = 0; i < 600; i++) tbl[i] = {32'h0000_0002, 32'h5000_0000 + 32'(16 * i)};
    rewind(32'h0004_0000); fresh();
    f0 = fetch_cnt;
    run(1100, 1'b0, 2, "R5 fail-safe exhausts");
    chk(obs_bytes == 1024, "R5 bytes before fail-safe", obs_bytes, 1024);
    chk(fetch_cnt - f0 == 512, "R5 descriptor count", fetch_cnt - f0, 512);

    // rewind restarts from base
    rewind(32'h0004_0000); fresh();
    f0 = fetch_cnt;
    run(10, 1'b1, 1, "R9 rewind run");
    chk(fetch_cnt - f0 == 5, "R4 fetches for 10 bytes", fetch_cnt - f0, 5);
    chk(last_fetch == 32'h0004_0020, "R4 R9 last fetch addr", last_fetch, 32'h0004_0020);

    repeat (4) @(negedge clk_i);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule